// File: doc/BRIEF.md
# Early-Release Physical Register File with Shadow Checkpoints

This block holds the physical registers of an out-of-order core together with a free list of register identifiers. Every register has a main copy, a shadow copy and one checkpointed flag. When the last reader of a value issues, the scheduler can request an early release. If the register is not already checkpointed, the block copies the live value into its shadow and sets the flag. It also returns the identifier to the free list at once. The value stays recoverable for precise squash handling until the redefining instruction commits.

At commit the reorder logic names the previous mapping of the destination. If that register was released early, only its checkpointed flag is cleared. Otherwise the identifier goes back to the free list. A recover request copies the shadow value back into main storage. Registers are grouped into banks. Each bank has a registered power-enable output, which drops only when no register in the bank is allocated or checkpointed.

Top module: `ckrf_top`

## Requirements
- R1: After synchronous reset, registers 0..NMAP-1 (default 32) count as allocated and nothing is checkpointed. The free list holds NMAP..NREG-1 in ascending order. did_early_rel, alloc_valid and alloc_stall are low. Exactly the banks that contain a register below NMAP are powered.
- R2: A write stores wr_data into main storage of wr_id. rd_data shows main storage of rd_id, registered one cycle after rd_id is presented.
- R3: An issue release on a register whose checkpointed flag is clear raises did_early_rel in the next cycle. At the edge that ends that cycle, the block copies main to shadow, sets the flag, clears the allocated state and pushes the identifier onto the free list.
- R4: An issue release on a register whose checkpointed flag is set leaves did_early_rel low and changes nothing.
- R5: A commit release with cmt_ckpt=1 only clears the checkpointed flag and pushes nothing. With cmt_ckpt=0 it clears the allocated state and pushes the identifier.
- R6: When an issue release and a commit release name the same register in the same cycle, the commit is performed and the issue release is dropped, so did_early_rel stays low.
- R7: When two identifiers are pushed at the same edge, the early-released identifier enters the free list ahead of the committed one.
- R8: A recover request copies shadow storage of rcv_id into its main storage. If a write targets the same register in that cycle, the recover wins.
- R9: Registers form banks of BANK (default 8) consecutive identifiers, 14 banks by default. bank_pwr_en[b] is registered and is high exactly when, before the previous edge, some register of bank b was allocated or checkpointed.
- R10: An allocation request with a non-empty free list returns the head identifier on alloc_id with alloc_valid high in the next cycle. The identifier counts as allocated from the edge after that. A request on an empty free list raises alloc_stall, with alloc_valid low, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Main-storage write strobe |
| wr_id | input | IDW | Register written |
| wr_data | input | DW | Write value |
| rd_id | input | IDW | Register read |
| rd_data | output | DW | Registered read value |
| iss_rel_en | input | 1 | Issue-time early release request |
| iss_rel_id | input | IDW | Register whose last reader issued |
| did_early_rel | output | 1 | Early release taken for the previous request |
| cmt_rel_en | input | 1 | Commit-time release request |
| cmt_rel_id | input | IDW | Previous mapping being released |
| cmt_ckpt | input | 1 | Released register was checkpointed |
| rcv_en | input | 1 | Recover request |
| rcv_id | input | IDW | Register restored from shadow |
| alloc_req | input | 1 | Pop a free identifier |
| alloc_valid | output | 1 | alloc_id holds a popped identifier |
| alloc_id | output | IDW | Popped identifier |
| alloc_stall | output | 1 | Pop requested with empty free list |
| bank_pwr_en | output | NBANK | Per-bank power enable |

## Verification
A stale or wrong checkpointed flag shows one cycle later as a wrong did_early_rel. It also shows as a bank power bit that stays high or drops too early. A corrupted free list shows in the order of the identifiers returned on alloc_id, or as a missing or early alloc_stall once the pops drain it. A missed shadow copy can only be seen after a recover followed by a read, which takes two cycles. The bench therefore checks every output on every cycle against a reference model, so any divergence is reported on the first cycle it reaches a port.

// File: rtl/ckrf_pkg.sv
package ckrf_pkg;
  // Successor of a ring pointer over a depth that need not be a power of two.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/ckrf_freelist.sv
module ckrf_freelist #(
  parameter int NREG = 112,
  parameter int NMAP = 32,
  localparam int IDW = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push0_en,
  input  logic [IDW-1:0] push0_id,
  input  logic           push1_en,
  input  logic [IDW-1:0] push1_id,
  input  logic           pop_req,
  output logic           pop_valid,
  output logic [IDW-1:0] pop_id,
  output logic           pop_stall,
  output logic [CW-1:0]  count
);
  logic [IDW-1:0] ring [NREG];
  logic [IDW-1:0] head, tail, wa0, wa1, tail_nx;
  logic do_pop;

  function automatic logic [IDW-1:0] nxt(input logic [IDW-1:0] p);
    return IDW'(ckrf_pkg::ring_next(int'(p), NREG));
  endfunction

  assign do_pop = pop_req && (count != '0);

  // Port 0 is written first, so it lands ahead of port 1.
  always_comb begin
    wa0 = tail;
    wa1 = push0_en ? nxt(tail) : tail;
    tail_nx = push1_en ? nxt(wa1) : wa1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++)
        ring[i] <= (i < NREG - NMAP) ? IDW'(NMAP + i) : '0;
      head      <= '0;
      tail      <= IDW'(NREG - NMAP);
      count     <= CW'(NREG - NMAP);
      pop_valid <= 1'b0;
      pop_stall <= 1'b0;
      pop_id    <= '0;
    end else begin
      if (push0_en) ring[wa0] <= push0_id;
      if (push1_en) ring[wa1] <= push1_id;
      tail      <= tail_nx;
      pop_valid <= do_pop;
      pop_stall <= pop_req && (count == '0);
      if (do_pop) begin
        pop_id <= ring[head];
        head   <= nxt(head);
      end
      count <= count + CW'(push0_en) + CW'(push1_en) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/ckrf_bankpwr.sv
module ckrf_bankpwr #(
  parameter int NREG = 112,
  parameter int BANK = 8,
  parameter int NMAP = 32,
  localparam int NBANK = NREG / BANK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREG-1:0]  live,
  input  logic [NREG-1:0]  held,
  output logic [NBANK-1:0] pwr
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) pwr[b] <= (b * BANK < NMAP);
      else     pwr[b] <= |(live[b*BANK +: BANK] | held[b*BANK +: BANK]);
    end
  end
endmodule

// File: rtl/ckrf_top.sv
module ckrf_top #(
  parameter int NREG = 112,
  parameter int BANK = 8,
  parameter int DW   = 16,
  parameter int NMAP = 32,
  localparam int IDW   = $clog2(NREG),
  localparam int NBANK = NREG / BANK,
  localparam int CW    = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDW-1:0]   wr_id,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDW-1:0]   rd_id,
  output logic [DW-1:0]    rd_data,
  input  logic             iss_rel_en,
  input  logic [IDW-1:0]   iss_rel_id,
  output logic             did_early_rel,
  input  logic             cmt_rel_en,
  input  logic [IDW-1:0]   cmt_rel_id,
  input  logic             cmt_ckpt,
  input  logic             rcv_en,
  input  logic [IDW-1:0]   rcv_id,
  input  logic             alloc_req,
  output logic             alloc_valid,
  output logic [IDW-1:0]   alloc_id,
  output logic             alloc_stall,
  output logic [NBANK-1:0] bank_pwr_en
);
  logic [DW-1:0]   main_q   [NREG];
  logic [DW-1:0]   shadow_q [NREG];
  logic [NREG-1:0] ckpt_q, alloc_q;
  logic            stg_v;
  logic [IDW-1:0]  stg_id;
  logic            cmt_push;
  logic [CW-1:0]   fl_count;

  // Issue stage: flag read alongside data; commit on same id wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v  <= 1'b0;
      stg_id <= '0;
    end else begin
      stg_v  <= iss_rel_en && !ckpt_q[iss_rel_id]
                && !(cmt_rel_en && cmt_rel_id == iss_rel_id);
      stg_id <= iss_rel_id;
    end
  end
  assign did_early_rel = stg_v;
  assign cmt_push      = cmt_rel_en && !cmt_ckpt;

  // Main storage: recover has priority over a write to the same entry.
  always_ff @(posedge clk) begin
    if (wr_en && !(rcv_en && rcv_id == wr_id)) main_q[wr_id] <= wr_data;
    if (rcv_en) main_q[rcv_id] <= shadow_q[rcv_id];
    rd_data <= main_q[rd_id];
  end

  always_ff @(posedge clk) begin
    if (stg_v) shadow_q[stg_id] <= main_q[stg_id];
  end

  // Flag state: set by early release, cleared afterwards by a commit.
  always_ff @(posedge clk) begin
    if (rst) begin
      ckpt_q <= '0;
      for (int i = 0; i < NREG; i++) alloc_q[i] <= (i < NMAP);
    end else begin
      if (alloc_valid) alloc_q[alloc_id] <= 1'b1;
      if (stg_v) begin
        ckpt_q[stg_id]  <= 1'b1;
        alloc_q[stg_id] <= 1'b0;
      end
      if (cmt_rel_en) begin
        if (cmt_ckpt) ckpt_q[cmt_rel_id]  <= 1'b0;
        else          alloc_q[cmt_rel_id] <= 1'b0;
      end
    end
  end

  ckrf_freelist #(.NREG(NREG), .NMAP(NMAP)) u_fl (
    .clk(clk), .rst(rst),
    .push0_en(stg_v), .push0_id(stg_id),
    .push1_en(cmt_push), .push1_id(cmt_rel_id),
    .pop_req(alloc_req), .pop_valid(alloc_valid), .pop_id(alloc_id),
    .pop_stall(alloc_stall), .count(fl_count)
  );

  ckrf_bankpwr #(.NREG(NREG), .BANK(BANK), .NMAP(NMAP)) u_pwr (
    .clk(clk), .rst(rst), .live(alloc_q), .held(ckpt_q), .pwr(bank_pwr_en)
  );
endmodule

// File: rtl/ckrf_checker.sv
module ckrf_checker #(
  parameter int NREG = 112,
  localparam int IDW = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            iss_rel_en,
  input logic [IDW-1:0]  iss_rel_id,
  input logic            cmt_rel_en,
  input logic [IDW-1:0]  cmt_rel_id,
  input logic            cmt_ckpt,
  input logic            alloc_req,
  input logic            alloc_valid,
  input logic            alloc_stall,
  input logic            did_early_rel,
  input logic [NREG-1:0] ckpt_q,
  input logic [IDW-1:0]  stg_id,
  input logic [CW-1:0]   fl_count
);
  assert_ckpt_set_R3: assert property (@(posedge clk) disable iff (rst)
    did_early_rel |=> (ckpt_q[$past(stg_id)]
                       || $past(cmt_rel_en && cmt_ckpt && cmt_rel_id == stg_id)));

  assert_no_rerelease_R4: assert property (@(posedge clk) disable iff (rst)
    (iss_rel_en && ckpt_q[iss_rel_id]) |=> !did_early_rel);

  assert_flag_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    (cmt_rel_en && cmt_ckpt) |=> !ckpt_q[$past(cmt_rel_id)]);

  assert_commit_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (iss_rel_en && cmt_rel_en && iss_rel_id == cmt_rel_id) |=> !did_early_rel);

  assert_stall_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && fl_count == '0) |=> (alloc_stall && !alloc_valid));

  always_ff @(posedge clk) begin
    if (!rst) assert_no_overflow_R10: assert (fl_count <= CW'(NREG));
  end
endmodule

bind ckrf_top ckrf_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .iss_rel_en(iss_rel_en), .iss_rel_id(iss_rel_id),
  .cmt_rel_en(cmt_rel_en), .cmt_rel_id(cmt_rel_id), .cmt_ckpt(cmt_ckpt),
  .alloc_req(alloc_req), .alloc_valid(alloc_valid), .alloc_stall(alloc_stall),
  .did_early_rel(did_early_rel), .ckpt_q(ckpt_q), .stg_id(stg_id),
  .fl_count(fl_count)
);

// File: tb/tb_ckrf_top.sv
`timescale 1ns/1ps
module tb_ckrf_top;
  localparam int NREG = 112, BANK = 8, DW = 16, NMAP = 32;
  localparam int IDW = $clog2(NREG), NBANK = NREG / BANK;

  logic clk = 0, rst = 1;
  logic wr_en = 0, iss_rel_en = 0, cmt_rel_en = 0, cmt_ckpt = 0, rcv_en = 0, alloc_req = 0;
  logic [IDW-1:0] wr_id = 0, rd_id = 0, iss_rel_id = 0, cmt_rel_id = 0, rcv_id = 0;
  logic [DW-1:0] wr_data = 0;
  logic [DW-1:0] rd_data;
  logic did_early_rel, alloc_valid, alloc_stall;
  logic [IDW-1:0] alloc_id;
  logic [NBANK-1:0] bank_pwr_en;

  always #10 clk = ~clk;

  ckrf_top #(.NREG(NREG), .BANK(BANK), .DW(DW), .NMAP(NMAP)) dut (.*);

  int nchk = 0, nfail = 0, ncyc = 0;
  bit done = 0;

  // Reference model
  bit m_alloc[NREG], m_ck[NREG], m_known[NREG], m_shv[NREG];
  logic [DW-1:0] m_main[NREG], m_sh[NREG];
  int q[$];
  bit m_stg = 0, m_pv = 0;
  int m_sid = 0, m_pid = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    bit e_did, e_val, e_stall, e_rdk;
    int e_aid;
    logic [DW-1:0] e_rd, rv, sv;
    logic [NBANK-1:0] e_pwr;
    e_did = iss_rel_en && !m_ck[iss_rel_id] && !(cmt_rel_en && cmt_rel_id == iss_rel_id);
    e_rdk = m_known[rd_id];
    e_rd  = m_main[rd_id];
    e_val = alloc_req && q.size() > 0;
    e_stall = alloc_req && q.size() == 0;
    e_aid = e_val ? q[0] : 0;
    for (int b = 0; b < NBANK; b++) begin
      e_pwr[b] = 0;
      for (int k = 0; k < BANK; k++)
        if (m_alloc[b*BANK+k] || m_ck[b*BANK+k]) e_pwr[b] = 1;
    end
    rv = m_sh[rcv_id];
    sv = m_main[m_sid];
    if (m_pv) m_alloc[m_pid] = 1;
    if (e_val) void'(q.pop_front());
    if (m_stg) begin
      m_sh[m_sid] = sv; m_shv[m_sid] = m_known[m_sid];
      m_ck[m_sid] = 1; m_alloc[m_sid] = 0; q.push_back(m_sid);
    end
    if (cmt_rel_en) begin
      if (cmt_ckpt) m_ck[cmt_rel_id] = 0;
      else begin m_alloc[cmt_rel_id] = 0; q.push_back(int'(cmt_rel_id)); end
    end
    if (wr_en && !(rcv_en && rcv_id == wr_id)) begin
      m_main[wr_id] = wr_data; m_known[wr_id] = 1;
    end
    if (rcv_en) m_main[rcv_id] = rv;
    m_stg = e_did; m_sid = iss_rel_id; m_pv = e_val; m_pid = e_aid;
    @(posedge clk); @(negedge clk); ncyc++;
    check(did_early_rel === e_did, "R3 R4 R6 did_early_rel", did_early_rel, e_did);
    if (e_rdk) check(rd_data === e_rd, "R2 R8 rd_data", rd_data, e_rd);
    check(alloc_valid === e_val, "R10 alloc_valid", alloc_valid, e_val);
    check(alloc_stall === e_stall, "R10 alloc_stall", alloc_stall, e_stall);
    if (e_val) check(alloc_id === IDW'(e_aid), "R10 R7 R5 alloc_id order", alloc_id, e_aid);
    check(bank_pwr_en === e_pwr, "R9 R5 bank_pwr_en", bank_pwr_en, e_pwr);
  endtask

  task automatic idle();
    wr_en = 0; iss_rel_en = 0; cmt_rel_en = 0; cmt_ckpt = 0; rcv_en = 0; alloc_req = 0;
  endtask

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < NREG; i++) begin
      m_alloc[i] = (i < NMAP); m_ck[i] = 0; m_known[i] = 0; m_shv[i] = 0;
      m_main[i] = 0; m_sh[i] = 0;
      if (i >= NMAP) q.push_back(i);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check(did_early_rel === 0 && alloc_valid === 0 && alloc_stall === 0,
          "R1 reset outputs", {did_early_rel, alloc_valid, alloc_stall}, 0);
    for (int b = 0; b < NBANK; b++)
      check(bank_pwr_en[b] === (b * BANK < NMAP), "R1 reset bank power", bank_pwr_en[b], b * BANK < NMAP);
    // R1: first pop returns NMAP
    alloc_req = 1; tick(); idle();
    // R2: fill main storage
    for (int i = 0; i < NREG; i++) begin
      wr_en = 1; wr_id = IDW'(i); wr_data = DW'($urandom); rd_id = IDW'(i == 0 ? 0 : i - 1);
      tick();
    end
    idle();
    // R10: drain free list into stall
    for (int i = 0; i < NREG - NMAP + 2; i++) begin alloc_req = 1; tick(); end
    idle(); tick();
    // R6: commit and issue release on the same register in one cycle
    iss_rel_en = 1; iss_rel_id = 5; cmt_rel_en = 1; cmt_rel_id = 5; cmt_ckpt = 0;
    tick(); idle(); tick();
    // R3 then R8: early release, overwrite, recover
    iss_rel_en = 1; iss_rel_id = 9; tick(); idle();
    wr_en = 1; wr_id = 9; wr_data = 16'hBEEF; rd_id = 9; tick(); idle();
    rcv_en = 1; rcv_id = 9; wr_en = 1; wr_id = 9; wr_data = 16'h1234; tick(); idle();
    rd_id = 9; tick(); tick();
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int a, c;
      idle();
      a = $urandom_range(NREG - 1);
      c = $urandom_range(NREG - 1);
      if ($urandom_range(2) != 0 && m_alloc[a] && !(m_stg && m_sid == a)) begin
        iss_rel_en = 1; iss_rel_id = IDW'(a);
      end
      if ($urandom_range(3) == 0 && iss_rel_en) c = a;
      if ($urandom_range(1) == 0) begin
        if (m_ck[c]) begin cmt_rel_en = 1; cmt_ckpt = 1; cmt_rel_id = IDW'(c); end
        else if (m_alloc[c] && !(m_stg && m_sid == c)) begin
          cmt_rel_en = 1; cmt_ckpt = 0; cmt_rel_id = IDW'(c);
        end
      end
      alloc_req = ($urandom_range(2) == 0);
      wr_en = ($urandom_range(3) == 0); wr_id = IDW'($urandom_range(NREG - 1)); wr_data = DW'($urandom);
      c = $urandom_range(NREG - 1);
      if (m_shv[c] && $urandom_range(4) == 0) begin rcv_en = 1; rcv_id = IDW'(c); end
      rd_id = IDW'($urandom_range(NREG - 1));
      tick();
    end
    idle(); tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule